// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar as packed BCD registers. A free-running oscillator tick (nominally 32.768 kHz) is divided down to a once-per-second step. Each step advances seconds, which carry into minutes, hours, day of week, date, month and a two-digit year. A century flag flips whenever the year wraps. Hours can be kept in 24-hour form or in 12-hour form with an AM/PM bit. Month lengths and leap years are handled in the date logic.

A host port sets the time by writing whole register bytes. Reads never look at the running counters. The serial front end pulses a load strobe when an access begins, and again when its register pointer wraps. That strobe copies all seven time registers into a snapshot bank in one edge. Reads are served from the snapshot, so a multi-byte read always sees one coherent instant while the counters keep running. Values that are not legal BCD, or that are out of range, give undefined results and are not checked.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00 (24-hour form), day of week 01, date 01, month 01 with century bit 0, and year 00. All fields are BCD.
- R2: Seconds advance by one on the edge of every TICKS_PER_SEC-th counted `osc_tick`. A write to the seconds register restarts this count, so the first step after the write comes TICKS_PER_SEC ticks later.
- R3: Seconds and minutes each count 00 to 59 and wrap to 00. A wrap carries one into the next field.
- R4: Hours bit 6 = 0 selects 24-hour form, with bits 5:4 as the tens digit. The hour counts 00 to 23, and the step out of 23:59:59 gives 00:00:00 and ends the day.
- R5: Hours bit 6 = 1 selects 12-hour form, with bit 5 as PM (1) and bits 4:0 as a BCD hour from 01 to 12. The hour steps 12 to 01 with no change of bit 5, and 11 to 12 with bit 5 inverted. The step out of PM 11:59:59 ends the day.
- R6: Day of week (register 3, bits 2:0) advances once per day end and wraps from 7 to 1.
- R7: Date (register 4) wraps to 01 after the last day of the month. April, June, September and November have 30 days, and February has 28, or 29 when the two-digit year is divisible by 4. All other months have 31 days.
- R8: Month (register 5, bits 4:0) wraps from 12 to 01 and carries into the year (register 6). A year step from 99 to 00 inverts the century bit (register 5, bit 7).
- R9: A host write (`wr_en`, register index on `wr_addr` with 0 = seconds, 1 = minutes, 2 = hours, 3 = day of week, 4 = date, 5 = month/century, 6 = year) takes effect at the next clock edge. An `osc_tick` in a write cycle is not counted.
- R10: A `snap_load` pulse copies all live registers into the snapshot at that edge. `rd_data` shows the snapshot byte selected by `rd_addr` (same index map), and the snapshot holds while `snap_load` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Index of the register to write |
| wr_data | input | 8 | Byte to write |
| snap_load | input | 1 | Copy the live time into the snapshot |
| rd_addr | input | 3 | Index of the snapshot byte to read |
| rd_data | output | 8 | Selected snapshot byte |

## Verification
A write and a counted tick both land at the first rising edge after they are driven. A `snap_load` lands at that same edge. `rd_data` follows `rd_addr` with no delay. So each result is due one edge after its stimulus, except that a seconds step needs exactly TICKS_PER_SEC counted ticks after the last seconds write. The bench drives inputs on the falling edge and pulses `snap_load` after the last tick. It then reads all seven bytes before the next load. This keeps every comparison in a settled half-cycle. The tick-count, write-cycle and snapshot-hold checks read at the exact tick or edge where a result must not yet have changed, and again one step later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    REG_SEC  = 3'd0,
    REG_MIN  = 3'd1,
    REG_HOUR = 3'd2,
    REG_DOW  = 3'd3,
    REG_DATE = 3'd4,
    REG_MON  = 3'd5,
    REG_YEAR = 3'd6
  } rtc_reg_e;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;
    logic [2:0] dow;
    logic [5:0] date;
    logic       cent;
    logic [4:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t RTC_POR = '{sec: 7'h00, min: 7'h00, hour: 7'h00,
                                    dow: 3'd1, date: 6'h01, cent: 1'b0,
                                    mon: 5'h01, year: 8'h00};

  // next BCD value of a two-digit field
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic is_leap(input logic [7:0] y);
    logic r;
    if (!y[4]) r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return r;
  endfunction

  // last BCD date of a month
  function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
    logic [5:0] r;
    case (m)
      5'h02:                      r = is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  input  logic restart,
  output logic sec_en
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          counted;

  assign counted = tick && !hold;
  assign sec_en  = counted && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (counted) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  // R2: without a tick or restart the division chain does not move
  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_q));

  // R9: an uncounted write cycle never produces a seconds step
  assert_write_blocks_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !sec_en);
endmodule

// File: rtl/rtc_clock_hms.sv
module rtc_clock_hms
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [6:0] sec,
  output logic [6:0] min,
  output logic [6:0] hour,
  output logic       day_end
);
  logic [6:0] sec_q, min_q, hour_q, hour_nx;
  logic [7:0] sec_inc, min_inc, h24_inc, h12_inc;
  logic       sec_wrap, min_wrap, hour_last;
  logic       unused_wr_top;

  assign unused_wr_top = wr_data[7];

  assign sec_inc  = bcd_inc({1'b0, sec_q});
  assign min_inc  = bcd_inc({1'b0, min_q});
  assign h24_inc  = bcd_inc({2'b00, hour_q[5:0]});
  assign h12_inc  = bcd_inc({3'b000, hour_q[4:0]});
  assign sec_wrap = (sec_q == 7'h59);
  assign min_wrap = (min_q == 7'h59);

  always_comb begin
    if (!hour_q[6]) begin
      hour_last = (hour_q[5:0] == 6'h23);
      hour_nx   = hour_last ? 7'h00 : {1'b0, h24_inc[5:0]};
    end else begin
      hour_last = hour_q[5] && (hour_q[4:0] == 5'h11);
      if (hour_q[4:0] == 5'h12)      hour_nx = {1'b1, hour_q[5], 5'h01};
      else if (hour_q[4:0] == 5'h11) hour_nx = {1'b1, ~hour_q[5], 5'h12};
      else                           hour_nx = {1'b1, hour_q[5], h12_inc[4:0]};
    end
  end

  assign day_end = step && sec_wrap && min_wrap && hour_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= RTC_POR.sec;
      min_q  <= RTC_POR.min;
      hour_q <= RTC_POR.hour;
    end else if (wr_en) begin
      case (wr_addr)
        REG_SEC:  sec_q  <= wr_data[6:0];
        REG_MIN:  min_q  <= wr_data[6:0];
        REG_HOUR: hour_q <= wr_data[6:0];
        default: ;
      endcase
    end else if (step) begin
      sec_q <= sec_wrap ? 7'h00 : sec_inc[6:0];
      if (sec_wrap) begin
        min_q <= min_wrap ? 7'h00 : min_inc[6:0];
        if (min_wrap) hour_q <= hour_nx;
      end
    end
  end

  assign sec  = sec_q;
  assign min  = min_q;
  assign hour = hour_q;

  // R3: seconds wrap to 00 and move the minutes
  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && sec_q == 7'h59) |=> (sec_q == 7'h00 && min_q != $past(min_q)));

  // R4: 24-hour day end lands on hour 00
  assert_h24_midnight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (day_end && !wr_en && !hour_q[6]) |=> (hour_q == 7'h00));

  // R5: the 11 -> 12 step in 12-hour form flips the PM bit
  assert_ampm_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && sec_wrap && min_wrap && hour_q[6] && hour_q[4:0] == 5'h11)
      |=> (hour_q[5] != $past(hour_q[5]) && hour_q[4:0] == 5'h12));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_step,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [2:0] dow,
  output logic [5:0] date,
  output logic       cent,
  output logic [4:0] mon,
  output logic [7:0] year
);
  logic [2:0] dow_q;
  logic [5:0] date_q;
  logic       cent_q;
  logic [4:0] mon_q;
  logic [7:0] year_q;
  logic [7:0] date_inc, mon_inc, year_inc;
  logic       month_end, year_end, cent_end;

  assign date_inc  = bcd_inc({2'b00, date_q});
  assign mon_inc   = bcd_inc({3'b000, mon_q});
  assign year_inc  = bcd_inc(year_q);
  assign month_end = (date_q == month_last(mon_q, year_q));
  assign year_end  = month_end && (mon_q == 5'h12);
  assign cent_end  = year_end && (year_q == 8'h99);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow_q  <= RTC_POR.dow;
      date_q <= RTC_POR.date;
      cent_q <= RTC_POR.cent;
      mon_q  <= RTC_POR.mon;
      year_q <= RTC_POR.year;
    end else if (wr_en) begin
      case (wr_addr)
        REG_DOW:  dow_q  <= wr_data[2:0];
        REG_DATE: date_q <= wr_data[5:0];
        REG_MON: begin
          cent_q <= wr_data[7];
          mon_q  <= wr_data[4:0];
        end
        REG_YEAR: year_q <= wr_data;
        default: ;
      endcase
    end else if (day_step) begin
      dow_q  <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      date_q <= month_end ? 6'h01 : date_inc[5:0];
      if (month_end) mon_q <= year_end ? 5'h01 : mon_inc[4:0];
      if (year_end) begin
        year_q <= cent_end ? 8'h00 : year_inc;
        if (cent_end) cent_q <= ~cent_q;
      end
    end
  end

  assign dow  = dow_q;
  assign date = date_q;
  assign cent = cent_q;
  assign mon  = mon_q;
  assign year = year_q;

  // R6: day of week wraps from 7 to 1
  assert_dow_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !wr_en && dow_q == 3'd7) |=> (dow_q == 3'd1));

  // R7: a leap February reaches the 29th
  assert_leap_feb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !wr_en && mon_q == 5'h02 && date_q == 6'h28 && is_leap(year_q))
      |=> (date_q == 6'h29 && mon_q == 5'h02));

  // R8: the end of year 99 flips the century bit
  assert_century_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !wr_en && cent_end) |=> (cent_q != $past(cent_q) && year_q == 8'h00));
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  rtc_time_t  live,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  rtc_time_t snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    snap_q <= RTC_POR;
    else if (load) snap_q <= live;
  end

  always_comb begin
    case (rd_addr)
      REG_SEC:  rd_data = {1'b0, snap_q.sec};
      REG_MIN:  rd_data = {1'b0, snap_q.min};
      REG_HOUR: rd_data = {1'b0, snap_q.hour};
      REG_DOW:  rd_data = {5'b0, snap_q.dow};
      REG_DATE: rd_data = {2'b0, snap_q.date};
      REG_MON:  rd_data = {snap_q.cent, 2'b0, snap_q.mon};
      REG_YEAR: rd_data = snap_q.year;
      default:  rd_data = 8'h00;
    endcase
  end

  // R10: the snapshot only changes on a load
  assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(snap_q));

  // R10: a load captures the live seconds
  assert_snap_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (snap_q.sec == $past(live.sec)));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       snap_load,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  logic      sec_en, day_end, sec_wr;
  rtc_time_t live;

  assign sec_wr = wr_en && (wr_addr == REG_SEC);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) presc_i (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .hold(wr_en),
    .restart(sec_wr), .sec_en(sec_en)
  );

  rtc_clock_hms hms_i (
    .clk(clk), .rst_n(rst_n), .step(sec_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .sec(live.sec), .min(live.min), .hour(live.hour), .day_end(day_end)
  );

  rtc_calendar cal_i (
    .clk(clk), .rst_n(rst_n), .day_step(day_end), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .dow(live.dow), .date(live.date), .cent(live.cent),
    .mon(live.mon), .year(live.year)
  );

  rtc_snapshot snap_i (
    .clk(clk), .rst_n(rst_n), .load(snap_load), .live(live),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R9: a write is visible in the live registers one edge later
  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_YEAR) |=> (live.year == $past(wr_data)));
endmodule

// File: tb/bcd_rtc_core_tb_top.sv
`timescale 1ns/100ps
module bcd_rtc_core_tb_top;
  localparam int TPS = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic       snap_load = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_year, m_cent;
  bit m_12h;

  always #4 clk = ~clk;

  bcd_rtc_core #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .snap_load(snap_load),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_byte(input int a);
    int h12;
    case (a)
      0: return bcd(m_sec);
      1: return bcd(m_min);
      2: begin
        if (!m_12h) return bcd(m_hr);
        h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
        return 8'h40 | ((m_hr >= 12) ? 8'h20 : 8'h00) | bcd(h12);
      end
      3: return 8'(m_dow);
      4: return bcd(m_date);
      5: return 8'((m_cent << 7)) | bcd(m_mon);
      default: return bcd(m_year);
    endcase
  endfunction

  task automatic model_second();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_dow = (m_dow == 7) ? 1 : m_dow + 1;
          m_date++;
          if (m_date > mdays(m_mon, m_year)) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_year++;
              if (m_year == 100) begin m_year = 0; m_cent ^= 1; end
            end
          end
        end
      end
    end
  endtask

  task automatic write_reg(input int a);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = exp_byte(a);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_all();
    for (int a = 6; a >= 0; a--) write_reg(a);
  endtask

  task automatic write_hms();
    write_reg(2); write_reg(1); write_reg(0);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    osc_tick = 1'b1;
    repeat (n) @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic read_check(input string req, input bit reload);
    if (reload) begin
      @(negedge clk); snap_load = 1'b1;
      @(negedge clk); snap_load = 1'b0;
    end
    for (int a = 0; a < 7; a++) begin
      rd_addr = 3'(a);
      #1;
      n_checks++;
      if (rd_data !== exp_byte(a)) begin
        n_fail++;
        $display("FAIL %s reg %0d: actual %02h expected %02h", req, a, rd_data, exp_byte(a));
      end
    end
  endtask

  task automatic set_model(input int hr, input int mi, input int s, input int dw,
                           input int dt, input int mo, input int yr, input int ce);
    m_hr = hr; m_min = mi; m_sec = s; m_dow = dw;
    m_date = dt; m_mon = mo; m_year = yr; m_cent = ce;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_12h = 1'b0;
    set_model(0, 0, 0, 1, 1, 1, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values seen through the snapshot
    read_check("R1", 1'b1);

    // R3 R4 R5: every hour boundary in both hour forms
    for (int md = 0; md < 2; md++) begin
      for (int h = 0; h < 24; h++) begin
        m_12h = (md == 1);
        set_model(h, 59, 58, 3, 15, 6, 10, 0);
        write_all();
        for (int k = 0; k < 3; k++) begin
          ticks(TPS);
          model_second();
          read_check(md == 1 ? "R3 R5" : "R3 R4", 1'b1);
        end
      end
    end

    // R6 R7 R8: month ends across leap, plain and final years
    m_12h = 1'b0;
    begin
      int ys[7] = '{0, 1, 2, 3, 4, 96, 99};
      for (int yi = 0; yi < 7; yi++) begin
        for (int mo = 1; mo <= 12; mo++) begin
          set_model(23, 59, 59, 7, 27, mo, ys[yi], yi % 2);
          write_all();
          for (int k = 0; k < 5; k++) begin
            ticks(TPS);
            model_second();
            read_check("R6 R7 R8", 1'b1);
            m_hr = 23; m_min = 59; m_sec = 59;
            write_hms();
          end
        end
      end
    end

    // R2: no step before the last tick of the second
    set_model(8, 30, 10, 2, 5, 5, 21, 0);
    write_all();
    ticks(TPS - 1);
    read_check("R2", 1'b1);
    ticks(1);
    model_second();
    read_check("R2", 1'b1);

    // R9: a tick during a write cycle is not counted
    ticks(TPS - 1);
    @(negedge clk);
    osc_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h44;
    @(negedge clk);
    osc_tick = 1'b0; wr_en = 1'b0;
    m_min = 44;
    read_check("R9", 1'b1);
    ticks(1);
    model_second();
    read_check("R9", 1'b1);

    // R10: snapshot holds while time runs on
    ticks(3 * TPS);
    read_check("R10", 1'b0);
    for (int k = 0; k < 3; k++) model_second();
    read_check("R10", 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule